// File: doc/BRIEF.md
# Scanned Control Memory Sequencer

This block is the digital heart of a sixteen-knob preset store. It visits sixteen control channels over and over, one fixed-length slot per channel. For each slot it points an external analog multiplexer at the channel, and in live mode it measures the selected voltage with a counting ramp: a 6-bit code climbs from zero once per conversion tick on a shared DAC while an external comparator reports whether the DAC output has passed the input. The count at which the comparator first trips, or full scale if it never does, is the measured value. When recording is armed, that value is written to an external 1024 x 6 memory at the slot's address.

In playback mode the ramp is idle and the stored word for the slot is read back instead. In both modes the DAC is then loaded with the slot's value (the fresh measurement in live mode, the memory word in playback), allowed to settle, and one of sixteen sample-and-hold strobes is pulsed so that the matching output holds the new level. The memory address is formed from a 3-bit bank, a 3-bit program and the 4-bit channel, so the memory holds 8 banks of 8 programs of 16 words.

Each slot runs through six states in a fixed ring: ST_LOAD (sample the bank, program, mode and record controls; clear the ramp) goes to ST_CONV unconditionally; ST_CONV (conversion window of 64 ticks) goes to ST_STORE on the 64th tick; ST_STORE (one cycle: memory write if recording, capture of the DAC value) goes to ST_SETTLE; ST_SETTLE goes to ST_STROBE after SETTLE_CYC cycles; ST_STROBE (one strobe line high) goes to ST_RELEASE after STROBE_CYC cycles; ST_RELEASE (strobe low, channel advances) goes back to ST_LOAD.

Top module: `ctlscan_seq`

## Requirements
- R1: The memory address is {bank, program, channel}: bank_sel in bits 9:7, prog_sel in bits 6:4, the channel in bits 3:0. bank_sel, prog_sel, play_mode and rec_en are sampled once at the start of each slot and held for that slot.
- R2: chan_sel starts at 0 after reset, stays constant for a whole slot and then steps by one, wrapping from 15 to 0.
- R3: In live mode (play_mode=0) the ramp code starts at 0 and, on each conversion tick (every CONV_DIV clocks), stops if cmp_above is 1 and otherwise increments; the result is the code at which it stopped. With a comparator that is high when the code exceeds a level v, the result is v+1.
- R4: If the code reaches 63 and the comparator has not tripped, conversion ends with result 63 and the code never wraps.
- R5: In live mode with rec_en=1, exactly one single-cycle write per slot is issued, after the conversion window and before the strobe, with mem_wdata equal to the result and mem_addr equal to the slot's address.
- R6: No write is issued when rec_en=0, and none in playback mode whatever rec_en is; stored words are then left unchanged.
- R7: In live mode dac_code follows the ramp code during the conversion window and equals the result while the strobe is high.
- R8: In playback mode dac_code equals the memory word at the slot's address while the strobe is high.
- R9: At most one strobe line is high, and only the line whose index equals chan_sel; dac_code is unchanged from at least one cycle before the strobe rises until it falls, and the strobe is low for at least one cycle before chan_sel changes.
- R10: During reset sh_strobe is 0, mem_we is 0, chan_sel is 0 and dac_code is 0.
- R11: Every slot lasts exactly 3 + 64*CONV_DIV + SETTLE_CYC + STROBE_CYC clocks in both modes, so strobe rising edges are that many clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_above | input | 1 | Comparator: 1 when the DAC output is above the selected channel input |
| bank_sel | input | 3 | Bank select |
| prog_sel | input | 3 | Program select within the bank |
| play_mode | input | 1 | 1 = playback from memory, 0 = live conversion |
| rec_en | input | 1 | 1 = store live results to memory |
| chan_sel | output | 4 | Channel select for the analog input multiplexer |
| dac_code | output | 6 | Code for the shared DAC |
| mem_addr | output | 10 | Memory word address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 6 | Memory write data |
| mem_rdata | input | 6 | Memory read data, one clock after the address |
| sh_strobe | output | 16 | One-hot sample-and-hold refresh strobes |

## Verification
The comparator trip test and the full-scale saturation test fall on the same tick when a channel's level is 62: the code reaches 63 and trips on the 64th tick, which is also the tick that closes the conversion window, while a level of 63 reaches full scale and never trips. Both levels sit in one channel pattern, and the bench expects 63 on the write data and on dac_code at the strobe for each, with the same slot length as every other channel. Channels at level 0 and mid-scale in the same sweep show that neither test fires early.

// File: rtl/ctlscan_pkg.sv
package ctlscan_pkg;

    // Slot sequence states
    typedef enum logic [2:0] {
        ST_LOAD    = 3'd0,
        ST_CONV    = 3'd1,
        ST_STORE   = 3'd2,
        ST_SETTLE  = 3'd3,
        ST_STROBE  = 3'd4,
        ST_RELEASE = 3'd5
    } scan_state_e;

    // Bits needed to count 0 .. n-1 (at least one bit)
    function automatic int unsigned count_width(input int unsigned n);
        if (n < 2) begin
            return 1;
        end
        return $clog2(n);
    endfunction

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ctlscan_tick.sv
// Conversion tick divider: one pulse every DIV clocks while not cleared.
module ctlscan_tick #(
    parameter int unsigned DIV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);
    localparam int unsigned CW = ctlscan_pkg::count_width(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = !clear && (cnt_q == LAST);

endmodule

// File: rtl/ctlscan_ramp.sv
// Counting ramp converter: climbs once per step until the comparator
// trips or full scale is reached, then freezes until cleared.
module ctlscan_ramp #(
    parameter int unsigned W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         step,
    input  logic         cmp_above,
    output logic [W-1:0] count,
    output logic         done
);
    localparam logic [W-1:0] FULL = {W{1'b1}};

    logic [W-1:0] count_q;
    logic         done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            done_q  <= 1'b0;
        end else if (clear) begin
            count_q <= '0;
            done_q  <= 1'b0;
        end else if (step && !done_q) begin
            if (cmp_above) begin
                done_q <= 1'b1;
            end else if (count_q == FULL) begin
                done_q <= 1'b1;
            end else begin
                count_q <= count_q + 1'b1;
            end
        end
    end

    assign count = count_q;
    assign done  = done_q;

endmodule

// File: rtl/ctlscan_strobe.sv
// Channel-to-strobe decoder, gated by the strobe phase.
module ctlscan_strobe #(
    parameter int unsigned CH_W = 4
) (
    input  logic                   enable,
    input  logic [CH_W-1:0]        chan,
    output logic [(1<<CH_W)-1:0]   strobe
);
    for (genvar i = 0; i < (1 << CH_W); i++) begin : g_line
        assign strobe[i] = enable && (chan == CH_W'(i));
    end

endmodule

// File: rtl/ctlscan_seq.sv
module ctlscan_seq #(
    parameter int unsigned CH_W       = 4,
    parameter int unsigned DATA_W     = 6,
    parameter int unsigned BANK_W     = 3,
    parameter int unsigned PROG_W     = 3,
    parameter int unsigned CONV_DIV   = 1000,
    parameter int unsigned SETTLE_CYC = 16,
    parameter int unsigned STROBE_CYC = 64
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cmp_above,
    input  logic [BANK_W-1:0]                bank_sel,
    input  logic [PROG_W-1:0]                prog_sel,
    input  logic                             play_mode,
    input  logic                             rec_en,
    output logic [CH_W-1:0]                  chan_sel,
    output logic [DATA_W-1:0]                dac_code,
    output logic [BANK_W+PROG_W+CH_W-1:0]    mem_addr,
    output logic                             mem_we,
    output logic [DATA_W-1:0]                mem_wdata,
    input  logic [DATA_W-1:0]                mem_rdata,
    output logic [(1<<CH_W)-1:0]             sh_strobe
);
    import ctlscan_pkg::*;

    localparam int unsigned NUM_CH = 1 << CH_W;
    localparam int unsigned PH_W   = count_width(max_of(SETTLE_CYC, STROBE_CYC));
    localparam logic [DATA_W-1:0] WIN_LAST    = {DATA_W{1'b1}};
    localparam logic [PH_W-1:0]   SETTLE_LAST = PH_W'(SETTLE_CYC - 1);
    localparam logic [PH_W-1:0]   STROBE_LAST = PH_W'(STROBE_CYC - 1);

    scan_state_e state_q, state_d;

    // Slot configuration, sampled in ST_LOAD
    logic [BANK_W-1:0] bank_q;
    logic [PROG_W-1:0] prog_q;
    logic              play_q;
    logic              rec_q;

    logic [CH_W-1:0]   chan_q;
    logic [DATA_W-1:0] win_q;    // conversion ticks elapsed in the window
    logic [PH_W-1:0]   ph_q;     // settle / strobe phase counter
    logic [DATA_W-1:0] hold_q;   // value refreshed onto the outputs

    logic              tick;
    logic              ramp_clear;
    logic              ramp_step;
    logic [DATA_W-1:0] ramp_cnt;
    logic              ramp_done;
    logic              strobe_en;
    logic [NUM_CH-1:0] strobe_lines;

    // ---------------------------------------------------------------
    // Sub-blocks
    // ---------------------------------------------------------------
    ctlscan_tick #(
        .DIV (CONV_DIV)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_q != ST_CONV),
        .tick  (tick)
    );

    assign ramp_clear = (state_q == ST_LOAD);
    assign ramp_step  = tick && !play_q;

    ctlscan_ramp #(
        .W (DATA_W)
    ) u_ramp (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (ramp_clear),
        .step      (ramp_step),
        .cmp_above (cmp_above),
        .count     (ramp_cnt),
        .done      (ramp_done)
    );

    assign strobe_en = (state_q == ST_STROBE);

    ctlscan_strobe #(
        .CH_W (CH_W)
    ) u_strobe (
        .enable (strobe_en),
        .chan   (chan_q),
        .strobe (strobe_lines)
    );

    // ---------------------------------------------------------------
    // State register
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOAD;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------------------------------------------------------
    // Next-state logic
    // ---------------------------------------------------------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD: begin
                state_d = ST_CONV;
            end
            ST_CONV: begin
                if (tick && (win_q == WIN_LAST)) begin
                    state_d = ST_STORE;
                end
            end
            ST_STORE: begin
                state_d = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (ph_q == SETTLE_LAST) begin
                    state_d = ST_STROBE;
                end
            end
            ST_STROBE: begin
                if (ph_q == STROBE_LAST) begin
                    state_d = ST_RELEASE;
                end
            end
            ST_RELEASE: begin
                state_d = ST_LOAD;
            end
            default: begin
                state_d = ST_LOAD;
            end
        endcase
    end

    // ---------------------------------------------------------------
    // Slot datapath registers
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
            prog_q <= '0;
            play_q <= 1'b0;
            rec_q  <= 1'b0;
            chan_q <= '0;
            win_q  <= '0;
            ph_q   <= '0;
            hold_q <= '0;
        end else begin
            unique case (state_q)
                ST_LOAD: begin
                    bank_q <= bank_sel;
                    prog_q <= prog_sel;
                    play_q <= play_mode;
                    rec_q  <= rec_en;
                    win_q  <= '0;
                end
                ST_CONV: begin
                    if (tick) begin
                        win_q <= win_q + 1'b1;
                    end
                end
                ST_STORE: begin
                    hold_q <= play_q ? mem_rdata : ramp_cnt;
                    ph_q   <= '0;
                end
                ST_SETTLE: begin
                    ph_q <= (ph_q == SETTLE_LAST) ? '0 : ph_q + 1'b1;
                end
                ST_STROBE: begin
                    ph_q <= (ph_q == STROBE_LAST) ? '0 : ph_q + 1'b1;
                end
                ST_RELEASE: begin
                    chan_q <= chan_q + 1'b1;
                end
                default: begin
                    ph_q <= '0;
                end
            endcase
        end
    end

    // ---------------------------------------------------------------
    // Outputs
    // ---------------------------------------------------------------
    always_comb begin
        chan_sel  = chan_q;
        mem_addr  = {bank_q, prog_q, chan_q};
        mem_wdata = ramp_cnt;
        mem_we    = (state_q == ST_STORE) && !play_q && rec_q && ramp_done;
        if ((state_q == ST_CONV) && !play_q) begin
            dac_code = ramp_cnt;
        end else begin
            dac_code = hold_q;
        end
        sh_strobe = strobe_lines;
    end

endmodule

// File: rtl/ctlscan_chk.sv
module ctlscan_chk #(
    parameter int unsigned CH_W   = 4,
    parameter int unsigned DATA_W = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [CH_W-1:0]      chan_sel,
    input logic [(1<<CH_W)-1:0] sh_strobe,
    input logic [DATA_W-1:0]    dac_code,
    input logic                 mem_we,
    input logic                 slot_play,
    input logic                 slot_rec,
    input logic [DATA_W-1:0]    ramp_cnt,
    input logic                 ramp_done,
    input logic                 ramp_clear
);
    localparam logic [DATA_W-1:0] FULL = {DATA_W{1'b1}};

    assert_strobe_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sh_strobe));

    assert_strobe_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_strobe != '0) |-> (sh_strobe[chan_sel] == 1'b1));

    assert_dac_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_strobe != '0) |-> $stable(dac_code));

    assert_strobe_low_before_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_sel != $past(chan_sel)) |-> ($past(sh_strobe) == '0));

    assert_chan_increment_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_sel != $past(chan_sel)) |-> (chan_sel == CH_W'($past(chan_sel) + 1'b1)));

    assert_write_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (!slot_play && slot_rec));

    assert_write_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    assert_write_outside_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (sh_strobe == '0));

    assert_ramp_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_done && !ramp_clear) |=> $stable(ramp_cnt));

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((ramp_cnt == FULL) && !ramp_clear) |=> (ramp_cnt == FULL));

endmodule

bind ctlscan_seq ctlscan_chk #(
    .CH_W   (CH_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .chan_sel   (chan_sel),
    .sh_strobe  (sh_strobe),
    .dac_code   (dac_code),
    .mem_we     (mem_we),
    .slot_play  (play_q),
    .slot_rec   (rec_q),
    .ramp_cnt   (ramp_cnt),
    .ramp_done  (ramp_done),
    .ramp_clear (ramp_clear)
);

// File: tb/ctlscan_seq_test.sv
module ctlscan_seq_test;

    localparam int CH_W       = 4;
    localparam int DATA_W     = 6;
    localparam int BANK_W     = 3;
    localparam int PROG_W     = 3;
    localparam int CONV_DIV   = 2;
    localparam int SETTLE_CYC = 2;
    localparam int STROBE_CYC = 3;
    localparam int ADDR_W     = BANK_W + PROG_W + CH_W;
    localparam int NUM_CH     = 1 << CH_W;
    localparam int SLOT_CYC   = 3 + (1 << DATA_W) * CONV_DIV + SETTLE_CYC + STROBE_CYC;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b1;
    logic                 cmp_above;
    logic [BANK_W-1:0]    bank_sel = '0;
    logic [PROG_W-1:0]    prog_sel = '0;
    logic                 play_mode = 1'b0;
    logic                 rec_en = 1'b0;
    logic [CH_W-1:0]      chan_sel;
    logic [DATA_W-1:0]    dac_code;
    logic [ADDR_W-1:0]    mem_addr;
    logic                 mem_we;
    logic [DATA_W-1:0]    mem_wdata;
    logic [DATA_W-1:0]    mem_rdata = '0;
    logic [NUM_CH-1:0]    sh_strobe;

    always #10 clk = ~clk;

    ctlscan_seq #(
        .CH_W (CH_W), .DATA_W (DATA_W), .BANK_W (BANK_W), .PROG_W (PROG_W),
        .CONV_DIV (CONV_DIV), .SETTLE_CYC (SETTLE_CYC), .STROBE_CYC (STROBE_CYC)
    ) uut (
        .clk (clk), .rst_n (rst_n), .cmp_above (cmp_above),
        .bank_sel (bank_sel), .prog_sel (prog_sel),
        .play_mode (play_mode), .rec_en (rec_en),
        .chan_sel (chan_sel), .dac_code (dac_code),
        .mem_addr (mem_addr), .mem_we (mem_we), .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata), .sh_strobe (sh_strobe)
    );

    // Analog model: per-channel level, comparator high when code exceeds it
    int ain [NUM_CH];
    assign cmp_above = (int'(dac_code) > ain[chan_sel]);

    function automatic int pattern(input int a);
        return (a * 37 + 11) % 64;
    endfunction

    function automatic int conv(input int level);
        return (level >= 63) ? 63 : level + 1;
    endfunction

    // Memory model, one-clock read latency
    logic [DATA_W-1:0] mem [1 << ADDR_W];
    logic do_fill = 1'b1;
    always @(posedge clk) begin
        if (do_fill) begin
            for (int i = 0; i < (1 << ADDR_W); i++) begin
                mem[i] <= DATA_W'(pattern(i));
            end
        end else begin
            if (mem_we) begin
                mem[mem_addr] <= mem_wdata;
            end
            mem_rdata <= mem[mem_addr];
        end
    end

    // Bench expectation state (written only by the main process)
    int gold [1 << ADDR_W];
    bit armed = 1'b0;
    bit exp_play = 1'b0;
    bit exp_rec = 1'b0;
    int exp_bank = 0;
    int exp_prog = 0;
    bit timed_out = 1'b0;

    // Monitor-owned counters
    int n_checks = 0;
    int n_fail = 0;
    int seen = 0;
    int wr_seen = 0;
    int exp_ch = 0;
    int cyc = 0;
    int last_rise = -1;
    logic [NUM_CH-1:0] prev_strobe = '0;
    int dac_at_rise = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            chk(sh_strobe == '0, "R10 strobe in reset", int'(sh_strobe), 0);
            chk(mem_we == 1'b0, "R10 write in reset", int'(mem_we), 0);
            chk(chan_sel == '0, "R10 channel in reset", int'(chan_sel), 0);
            chk(dac_code == '0, "R10 dac in reset", int'(dac_code), 0);
        end else begin
            if (!armed) begin
                seen = 0;
                wr_seen = 0;
                exp_ch = 0;
            end
            if (mem_we && armed) begin
                int wa;
                wr_seen++;
                wa = (exp_bank << (PROG_W + CH_W)) | (exp_prog << CH_W) | int'(chan_sel);
                chk(!exp_play && exp_rec, "R6 write not allowed", 1, 0);
                chk(int'(mem_addr) == wa, "R1 write address", int'(mem_addr), wa);
                chk(int'(mem_wdata) == conv(ain[chan_sel]), "R5 write data",
                    int'(mem_wdata), conv(ain[chan_sel]));
            end
            if ((sh_strobe != '0) && (prev_strobe == '0)) begin
                if (last_rise >= 0) begin
                    chk(cyc - last_rise == SLOT_CYC, "R11 slot length", cyc - last_rise, SLOT_CYC);
                end
                last_rise = cyc;
                dac_at_rise = int'(dac_code);
                if (armed) begin
                    int ea;
                    int ev;
                    chk(sh_strobe == (NUM_CH'(1) << chan_sel), "R9 strobe line",
                        int'(sh_strobe), 1 << chan_sel);
                    chk(int'(chan_sel) == exp_ch, "R2 channel order", int'(chan_sel), exp_ch);
                    if (exp_play) begin
                        ea = (exp_bank << (PROG_W + CH_W)) | (exp_prog << CH_W) | int'(chan_sel);
                        ev = gold[ea];
                        chk(int'(dac_code) == ev, "R8 playback value", int'(dac_code), ev);
                    end else begin
                        ev = conv(ain[chan_sel]);
                        if (ain[chan_sel] >= 62) begin
                            chk(int'(dac_code) == ev, "R4 full-scale result", int'(dac_code), ev);
                        end else begin
                            chk(int'(dac_code) == ev, "R3 R7 live result", int'(dac_code), ev);
                        end
                    end
                    exp_ch = (exp_ch + 1) % NUM_CH;
                    seen++;
                    if (seen == NUM_CH) begin
                        if (!exp_play && exp_rec) begin
                            chk(wr_seen == NUM_CH, "R5 writes per scan", wr_seen, NUM_CH);
                        end else begin
                            chk(wr_seen == 0, "R6 writes per scan", wr_seen, 0);
                        end
                    end
                end
            end else if (sh_strobe != '0) begin
                chk(int'(dac_code) == dac_at_rise, "R9 dac steady under strobe",
                    int'(dac_code), dac_at_rise);
            end
            prev_strobe = sh_strobe;
        end
    end

    task automatic set_levels_a();
        int lv [NUM_CH] = '{0, 1, 5, 10, 20, 30, 31, 32, 40, 50, 60, 61, 62, 63, 63, 17};
        for (int c = 0; c < NUM_CH; c++) ain[c] = lv[c];
    endtask

    task automatic set_levels_b();
        for (int c = 0; c < NUM_CH; c++) ain[c] = (c * 5 + 3) % 64;
    endtask

    // Start a scan: inputs change while the last slot of the previous
    // scan finishes, and take effect at the next channel-0 slot.
    task automatic next_scan(input bit play, input bit rec, input int bank, input int prog);
        wait (seen == NUM_CH);
        armed = 1'b0;
        play_mode = play;
        rec_en = rec;
        bank_sel = BANK_W'(bank);
        prog_sel = PROG_W'(prog);
        @(negedge clk);
        while (chan_sel != '0) @(negedge clk);
        exp_play = play;
        exp_rec = rec;
        exp_bank = bank;
        exp_prog = prog;
        armed = 1'b1;
    endtask

    task automatic record_gold(input int bank, input int prog);
        for (int c = 0; c < NUM_CH; c++) begin
            gold[(bank << (PROG_W + CH_W)) | (prog << CH_W) | c] = conv(ain[c]);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_checks, n_fail + (timed_out ? 1 : 0));
    endtask

    initial begin
        for (int i = 0; i < (1 << ADDR_W); i++) gold[i] = pattern(i);
        set_levels_a();
        #5 rst_n = 1'b0;
        repeat (4) @(negedge clk);
        do_fill = 1'b0;
        // Scan 1: live, recording into bank 2 program 5 (R3 R4 R5 R7)
        play_mode = 1'b0;
        rec_en = 1'b1;
        bank_sel = 3'd2;
        prog_sel = 3'd5;
        exp_play = 1'b0;
        exp_rec = 1'b1;
        exp_bank = 2;
        exp_prog = 5;
        @(negedge clk);
        rst_n = 1'b1;
        armed = 1'b1;
        record_gold(2, 5);
        // Scan 2: playback of that program with record held high (R6 R8)
        next_scan(1'b1, 1'b1, 2, 5);
        // Scan 3: playback of an untouched program in the top bank (R1 R8)
        next_scan(1'b1, 1'b0, 7, 7);
        // Scan 4: live without record, different levels (R6 R7)
        set_levels_b();
        next_scan(1'b0, 1'b0, 2, 5);
        // Scan 5: stored words must be unchanged (R6)
        next_scan(1'b1, 1'b0, 2, 5);
        // Scan 6: live record of pattern B into bank 0 program 1 (R1 R5)
        next_scan(1'b0, 1'b1, 0, 1);
        record_gold(0, 1);
        // Scan 7 and 8: read both back (R1 R8)
        next_scan(1'b1, 1'b0, 0, 1);
        next_scan(1'b1, 1'b0, 0, 0);
        wait (seen == NUM_CH);
        @(negedge clk);
        report();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        timed_out = 1'b1;
        $display("FAIL watchdog: actual %0d cycles expected completion", 200000);
        report();
        $finish;
    end

endmodule